// File: doc/BRIEF.md
# Endpoint-Zero Control and Status Register

This block holds the control and status register of the control endpoint in a USB device controller, along with the handshake logic around it. Firmware reaches it through a simple register port: a write strobe with write data, a read strobe, and read data. The protocol engine reports four events to it: an OUT packet has been stored in the endpoint FIFO, the host has acknowledged the pending IN packet, a protocol violation made the endpoint send a stall, and the status stage of the control transfer has finished.

Each of the four flags follows its own access rule. The receive-ready flag is set by hardware and can be cleared only through a separate strobe bit. The transmit-ready flag is set by firmware and cleared by hardware. The stall flag is set by hardware and cleared when firmware writes zero to it. The last-packet flag is set by firmware and cleared by hardware. Every hardware event that firmware must service raises one sticky interrupt request. Firmware clears that request by reading the register. The two packet-ready flags also go out directly to the protocol engine.

Top module: `ep0_ctrl_reg`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four flags, the interrupt request, `out_pkt_rdy`, `in_pkt_rdy` and every bit of `reg_rdata` are 0.
- R2: Bit 0 is the receive-ready flag. An `evt_out_stored` pulse sets it and raises the interrupt request in the following cycle. Writing bit 0, with either value, has no effect on it.
- R3: A write with bit 6 (the clear-out strobe) at 1 clears the receive-ready flag in the following cycle. Bit 6 always reads back as 0.
- R4: Bit 1 is the transmit-ready flag. A write with bit 1 at 1 sets it. A write with bit 1 at 0 leaves it unchanged.
- R5: `evt_in_acked` clears the transmit-ready flag and raises the interrupt request, but only while the flag is 1. When the flag is 0, the event changes nothing and raises no interrupt.
- R6: Bit 2 is the stall flag. `evt_stall` sets it and raises the interrupt request. A write with bit 2 at 0 clears it. A write with bit 2 at 1 leaves it unchanged.
- R7: Bit 3 is the last-packet flag. A write with bit 3 at 1 sets it, and it may be combined in the same write with bit 1 (this also covers a zero-length data phase) or with bit 6. `evt_status_done` clears it. A write with bit 3 at 0 has no effect. This flag raises no interrupt.
- R8: When a hardware event and a firmware write act on the same flag in the same cycle, the hardware action takes effect.
- R9: The interrupt request stays high until a cycle in which `reg_re` is asserted, and it is low from the next cycle on. A new interrupt source in the same cycle as the read keeps it high.
- R10: `out_pkt_rdy` and `in_pkt_rdy` equal read-data bits 0 and 1. Bits 4 and above of `reg_rdata` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_re | input | 1 | Register read strobe; acknowledges the interrupt |
| reg_rdata | output | REG_W | Current register contents |
| evt_out_stored | input | 1 | An OUT packet has been stored in the FIFO |
| evt_in_acked | input | 1 | The host has acknowledged the IN packet |
| evt_stall | input | 1 | A stall was sent after a protocol violation |
| evt_status_done | input | 1 | The status stage has completed |
| out_pkt_rdy | output | 1 | Receive-ready flag, to the protocol engine |
| in_pkt_rdy | output | 1 | Transmit-ready flag, to the protocol engine |
| irq | output | 1 | Sticky interrupt request |

## Verification
Every flag and the interrupt request are registered. An event or write that is present before a rising edge therefore shows on the flags, on `reg_rdata` and on `irq` right after that edge, which is exactly one cycle of latency. Read data has no further delay, because it is a combinational view of the flags. The bench applies each stimulus at a falling edge and steps a behavioural model at the next rising edge using that same stimulus. It then compares every output at the following falling edge, so every result is checked in the single cycle in which it is due.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
   // bit positions firmware depends on
   localparam int OUT_RDY_IDX = 0;
   localparam int IN_RDY_IDX  = 1;
   localparam int STALL_IDX   = 2;
   localparam int DEND_IDX    = 3;
   localparam int CLR_OUT_IDX = 6;
   localparam int NUM_FLAGS   = 4;

   typedef struct packed {
      logic out_stored;
      logic in_acked;
      logic stall;
      logic status_done;
   } ep0_evt_t;
endpackage

// File: rtl/ep0_flag_bit.sv
module ep0_flag_bit #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic hw_clr,
   input  logic sw_set,
   input  logic sw_clr,
   output logic q
);
   // priority: hardware set, hardware clear, firmware set, firmware clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RST_VAL;
      else if (hw_set) q <= 1'b1;
      else if (hw_clr) q <= 1'b0;
      else if (sw_set) q <= 1'b1;
      else if (sw_clr) q <= 1'b0;
   end

   // R8
   hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> q);
   // R8
   hw_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clr && !hw_set) |=> !q);
endmodule

// File: rtl/ep0_csr_decode.sv
module ep0_csr_decode
   import ep0_csr_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic                 we,
   input  logic [REG_W-1:0]     wdata,
   input  ep0_evt_t             evt,
   input  logic [NUM_FLAGS-1:0] cur,
   output logic [NUM_FLAGS-1:0] hw_set,
   output logic [NUM_FLAGS-1:0] hw_clr,
   output logic [NUM_FLAGS-1:0] sw_set,
   output logic [NUM_FLAGS-1:0] sw_clr,
   output logic                 irq_src
);
   logic unused_wbits;
   assign unused_wbits = ^wdata;

   always_comb begin
      hw_set = '0;
      hw_clr = '0;
      sw_set = '0;
      sw_clr = '0;
      // receive-ready: hardware sets, strobe clears
      hw_set[OUT_RDY_IDX] = evt.out_stored;
      sw_clr[OUT_RDY_IDX] = we & wdata[CLR_OUT_IDX];
      // transmit-ready: firmware sets, acknowledge clears a pending packet
      sw_set[IN_RDY_IDX]  = we & wdata[IN_RDY_IDX];
      hw_clr[IN_RDY_IDX]  = evt.in_acked & cur[IN_RDY_IDX];
      // stall: hardware sets, writing zero clears
      hw_set[STALL_IDX]   = evt.stall;
      sw_clr[STALL_IDX]   = we & ~wdata[STALL_IDX];
      // last packet: firmware sets, status stage clears
      sw_set[DEND_IDX]    = we & wdata[DEND_IDX];
      hw_clr[DEND_IDX]    = evt.status_done;
   end

   assign irq_src = hw_set[OUT_RDY_IDX] | hw_clr[IN_RDY_IDX] | hw_set[STALL_IDX];
endmodule

// File: rtl/ep0_irq_pend.sv
module ep0_irq_pend #(
   parameter bit READ_ACK_WINS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic pend
);
   generate
      if (READ_ACK_WINS) begin : g_ack_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pend <= 1'b0;
            else if (ack) pend <= 1'b0;
            else if (set) pend <= 1'b1;
         end
      end else begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pend <= 1'b0;
            else if (set) pend <= 1'b1;
            else if (ack) pend <= 1'b0;
         end
         // R9
         irq_keep_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set |=> pend);
      end
   endgenerate

   // R9
   irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !set) |=> !pend);
endmodule

// File: rtl/ep0_ctrl_reg.sv
module ep0_ctrl_reg
   import ep0_csr_pkg::*;
#(
   parameter int REG_W         = 8,
   parameter bit READ_ACK_WINS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             reg_re,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             evt_out_stored,
   input  logic             evt_in_acked,
   input  logic             evt_stall,
   input  logic             evt_status_done,
   output logic             out_pkt_rdy,
   output logic             in_pkt_rdy,
   output logic             irq
);
   localparam int MIN_W = CLR_OUT_IDX + 1;

   generate
      if (REG_W < MIN_W || REG_W > 32) begin : g_bad_width
         $error("ep0_ctrl_reg: REG_W must lie between %0d and 32", MIN_W);
      end
   endgenerate

   ep0_evt_t             evt;
   logic [NUM_FLAGS-1:0] flags;
   logic [NUM_FLAGS-1:0] hw_set, hw_clr, sw_set, sw_clr;
   logic                 irq_src;

   assign evt = '{out_stored: evt_out_stored, in_acked: evt_in_acked,
                  stall: evt_stall, status_done: evt_status_done};

   ep0_csr_decode #(.REG_W(REG_W)) u_dec (
      .we      (reg_we),
      .wdata   (reg_wdata),
      .evt     (evt),
      .cur     (flags),
      .hw_set  (hw_set),
      .hw_clr  (hw_clr),
      .sw_set  (sw_set),
      .sw_clr  (sw_clr),
      .irq_src (irq_src)
   );

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         ep0_flag_bit #(.RST_VAL(1'b0)) u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (hw_set[i]),
            .hw_clr (hw_clr[i]),
            .sw_set (sw_set[i]),
            .sw_clr (sw_clr[i]),
            .q      (flags[i])
         );
      end
   endgenerate

   ep0_irq_pend #(.READ_ACK_WINS(READ_ACK_WINS)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (irq_src),
      .ack   (reg_re),
      .pend  (irq)
   );

   // the strobe position and the upper bits stay zero
   always_comb begin
      reg_rdata = '0;
      reg_rdata[NUM_FLAGS-1:0] = flags;
   end

   assign out_pkt_rdy = flags[OUT_RDY_IDX];
   assign in_pkt_rdy  = flags[IN_RDY_IDX];

   // R2
   out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_out_stored |=> (out_pkt_rdy && irq));
   // R2
   out_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !reg_wdata[CLR_OUT_IDX] && !evt_out_stored) |=>
      (out_pkt_rdy == $past(out_pkt_rdy)));
   // R3
   clr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_wdata[CLR_OUT_IDX] && !evt_out_stored) |=> !out_pkt_rdy);
   // R4
   in_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_wdata[IN_RDY_IDX] && !evt_in_acked) |=> in_pkt_rdy);
   // R5
   in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_pkt_rdy && evt_in_acked) |=> (!in_pkt_rdy && irq));
   // R6
   stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_stall |=> (reg_rdata[STALL_IDX] && irq));
   // R6
   stall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !reg_wdata[STALL_IDX] && !evt_stall) |=> !reg_rdata[STALL_IDX]);
   // R7
   dend_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_status_done |=> !reg_rdata[DEND_IDX]);
   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !reg_re) |=> irq);
endmodule

// File: tb/tb_ep0_ctrl_reg.sv
`timescale 1ns/1ps
module tb_ep0_ctrl_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0, reg_re = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       evt_out_stored = 1'b0, evt_in_acked = 1'b0;
   logic       evt_stall = 1'b0, evt_status_done = 1'b0;
   logic       out_pkt_rdy, in_pkt_rdy, irq;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   // reference state
   bit m_out, m_in, m_stall, m_dend, m_irq;

   always #2 clk = ~clk;

   ep0_ctrl_reg #(.REG_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_re(reg_re), .reg_rdata(reg_rdata), .evt_out_stored(evt_out_stored),
      .evt_in_acked(evt_in_acked), .evt_stall(evt_stall),
      .evt_status_done(evt_status_done), .out_pkt_rdy(out_pkt_rdy),
      .in_pkt_rdy(in_pkt_rdy), .irq(irq)
   );

   task automatic compare(input string tag);
      logic [10:0] act, exp;
      act = {irq, in_pkt_rdy, out_pkt_rdy, reg_rdata};
      exp = {m_irq, m_in, m_out, 4'b0000, m_dend, m_stall, m_in, m_out};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: {irq,in,out,rdata} actual %b expected %b",
                  tag, $time, act, exp);
      end
   endtask

   task automatic step(input string tag, input bit we, input logic [7:0] wd,
                       input bit re, input bit eo, input bit ei,
                       input bit es, input bit ed);
      bit src;
      reg_we = we; reg_wdata = wd; reg_re = re;
      evt_out_stored = eo; evt_in_acked = ei; evt_stall = es; evt_status_done = ed;
      @(posedge clk);
      src = eo || (ei && m_in) || es;
      if (eo) m_out = 1; else if (we && wd[6]) m_out = 0;
      if (ei && m_in) m_in = 0; else if (we && wd[1]) m_in = 1;
      if (es) m_stall = 1; else if (we && !wd[2]) m_stall = 0;
      if (ed) m_dend = 0; else if (we && wd[3]) m_dend = 1;
      if (src) m_irq = 1; else if (re) m_irq = 0;
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");                            // during reset
      rst_n = 1'b1;
      step("R1", 0, 8'h00, 0, 0, 0, 0, 0);
      step("R2", 1, 8'h01, 0, 0, 0, 0, 0);      // bit 0 is not writable
      step("R2", 0, 8'h00, 0, 1, 0, 0, 0);      // set + irq
      step("R9", 0, 8'h00, 1, 0, 0, 0, 0);      // read acks irq
      step("R2", 1, 8'h00, 0, 0, 0, 0, 0);      // writing 0 keeps it
      step("R3", 1, 8'h40, 0, 0, 0, 0, 0);      // strobe clears, reads 0
      step("R8", 1, 8'h40, 0, 1, 0, 0, 0);      // event beats strobe
      step("R9", 0, 8'h00, 1, 0, 0, 1, 0);      // new source during read
      step("R6", 1, 8'h04, 0, 0, 0, 0, 0);      // writing 1 keeps stall
      step("R6", 1, 8'h00, 0, 0, 0, 0, 0);      // writing 0 clears stall
      step("R9", 0, 8'h00, 1, 0, 0, 0, 0);
      step("R9", 0, 8'h00, 0, 0, 0, 0, 0);      // stays low
      step("R5", 0, 8'h00, 0, 0, 1, 0, 0);      // ack while idle: nothing
      step("R4", 1, 8'h02, 0, 0, 0, 0, 0);
      step("R4", 1, 8'h00, 0, 0, 0, 0, 0);
      step("R5", 0, 8'h00, 0, 0, 1, 0, 0);      // clears + irq
      step("R9", 0, 8'h00, 1, 0, 0, 0, 0);
      step("R7", 1, 8'h0A, 0, 0, 0, 0, 0);      // zero-length phase
      step("R7", 1, 8'h00, 0, 0, 0, 0, 0);      // writing 0 no effect
      step("R7", 0, 8'h00, 0, 0, 0, 0, 1);      // status done clears
      step("R7", 1, 8'h48, 0, 0, 0, 0, 0);      // last OUT packet
      step("R8", 1, 8'h08, 0, 0, 0, 0, 1);      // status done beats set
      step("R8", 1, 8'h00, 0, 0, 0, 1, 0);      // stall beats clear
      step("R8", 1, 8'h02, 0, 0, 1, 0, 0);      // ack beats set
      step("R10", 1, 8'hB4, 0, 0, 0, 0, 0);     // upper bits read 0
      for (int i = 0; i < 600; i++) begin
         logic [7:0] w;
         w = 8'($urandom);
         step("R8", ($urandom % 3) == 0, w, ($urandom % 4) == 0,
              ($urandom % 6) == 0, ($urandom % 5) == 0,
              ($urandom % 7) == 0, ($urandom % 6) == 0);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule